// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier

This block multiplies two 16-bit integers, or a 16-bit integer and a small unsigned constant, or two bytes. The caller selects how each operand is read (signed or unsigned) through a 3-bit mode code. Every mode runs through one signed 17-by-17 product array. Before the multiply, each operand is widened by one bit. A signed operand is sign-extended and an unsigned one is zero-extended. After widening, the array never has to know which signedness the caller asked for.

The caller presents the operands, the 5-bit literal and the mode together with a one-cycle valid strobe. The low 32 bits of the product appear on the output register on the next rising clock edge, together with a one-cycle output valid pulse. Between strobes the output register keeps the last result.

Top module: `mulx_top`

## Requirements
- R1: Mode code 0 treats both `a_i` and `b_i` as two's-complement values, and the 32-bit result is their product (for example 0x8000 times 0x8000 gives 0x40000000).
- R2: Mode code 1 treats both `a_i` and `b_i` as unsigned, and the result is their 32-bit unsigned product (0xFFFF times 0xFFFF gives 0xFFFE0001).
- R3: Mode code 2 reads `a_i` as unsigned and `b_i` as signed. Mode code 3 reads `a_i` as signed and `b_i` as unsigned. The result is the low 32 bits of the two's-complement product.
- R4: Mode code 4 multiplies a signed `a_i` by the zero-extended 5-bit `lit_i`, and `b_i` has no effect.
- R5: Mode code 5 multiplies an unsigned `a_i` by the zero-extended `lit_i`. The result never exceeds 21 bits, and `b_i` has no effect.
- R6: Mode code 6 multiplies the low bytes of `a_i` and `b_i` as unsigned values. The upper bytes have no effect, and result bits 31:16 are zero.
- R7: Mode code 7 is reserved and yields a product of zero.
- R8: `product_o` and `valid_o` change on the first rising edge after a cycle in which `valid_i` is high. `valid_o` is high for exactly one cycle per strobe cycle, so strobes in back-to-back cycles give results in back-to-back cycles.
- R9: While `valid_i` is low, `product_o` holds its last value and input changes have no effect on it.
- R10: While `rst_n` is low, `product_o` is zero and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| mode_i | input | 3 | Product mode code (0 to 7, see requirements) |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| lit_i | input | 5 | Unsigned literal for modes 4 and 5 |
| valid_o | output | 1 | One-cycle pulse marking a new product |
| product_o | output | 32 | Low 32 bits of the product |

## Verification
The bench builds the block with its default widths: 16-bit operands, a 5-bit literal and 8-bit bytes. This brings every extreme operand within reach: 0x8000, 0xFFFF, 0x7FFF and a literal of 31. At these values the sign and zero extension into the seventeenth bit decides the result, and the low 32 bits of the wide product are the only bits that survive. Directed cases also place nonzero data in the bits that a mode must ignore: the upper bytes in byte mode, and `b_i` in the literal modes. They also check that the output register holds between strobes and answers back-to-back strobes.

// File: rtl/mulx_pkg.sv
`timescale 1ns/1ps
package mulx_pkg;

    // Mode codes for the multiplier; the value is what mode_i carries.
    typedef enum logic [2:0] {
        MODE_SS  = 3'd0,  // signed   x signed
        MODE_UU  = 3'd1,  // unsigned x unsigned
        MODE_US  = 3'd2,  // unsigned a x signed b
        MODE_SU  = 3'd3,  // signed a x unsigned b
        MODE_SL  = 3'd4,  // signed a x unsigned literal
        MODE_UL  = 3'd5,  // unsigned a x unsigned literal
        MODE_B8  = 3'd6,  // low byte x low byte, unsigned
        MODE_RSV = 3'd7   // reserved, product forced to zero
    } mulx_mode_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/mulx_operand_prep.sv
`timescale 1ns/1ps
module mulx_operand_prep
    import mulx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LIT_W  = 5,
    parameter int BYTE_W = 8,
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [LIT_W-1:0]  lit_i,
    output logic [EXT_W-1:0]  a_ext_o,
    output logic [EXT_W-1:0]  b_ext_o
);

    logic [EXT_W-1:0] a_sx, a_zx, b_sx, b_zx, lit_zx, a_byte, b_byte;

    // Widened forms of each operand; the mode picks one per side.
    always_comb begin
        a_sx   = {a_i[DATA_W-1], a_i};
        a_zx   = {1'b0, a_i};
        b_sx   = {b_i[DATA_W-1], b_i};
        b_zx   = {1'b0, b_i};
        lit_zx = {{(EXT_W-LIT_W){1'b0}}, lit_i};
        a_byte = {{(EXT_W-BYTE_W){1'b0}}, a_i[BYTE_W-1:0]};
        b_byte = {{(EXT_W-BYTE_W){1'b0}}, b_i[BYTE_W-1:0]};
    end

    always_comb begin
        a_ext_o = '0;
        b_ext_o = '0;
        unique case (mulx_mode_e'(mode_i))
            MODE_SS:  begin a_ext_o = a_sx;   b_ext_o = b_sx;   end
            MODE_UU:  begin a_ext_o = a_zx;   b_ext_o = b_zx;   end
            MODE_US:  begin a_ext_o = a_zx;   b_ext_o = b_sx;   end
            MODE_SU:  begin a_ext_o = a_sx;   b_ext_o = b_zx;   end
            MODE_SL:  begin a_ext_o = a_sx;   b_ext_o = lit_zx; end
            MODE_UL:  begin a_ext_o = a_zx;   b_ext_o = lit_zx; end
            MODE_B8:  begin a_ext_o = a_byte; b_ext_o = b_byte; end
            default:  begin a_ext_o = '0;     b_ext_o = '0;     end
        endcase
    end

endmodule

// File: rtl/mulx_core.sv
`timescale 1ns/1ps
module mulx_core #(
    parameter int EXT_W  = 17,
    localparam int FULL_W = 2 * EXT_W
) (
    input  logic [EXT_W-1:0]  x_i,
    input  logic [EXT_W-1:0]  y_i,
    output logic [FULL_W-1:0] p_o
);

    logic signed [FULL_W-1:0] x_wide, y_wide;

    // Both inputs are two's-complement; widen to full width, then multiply.
    always_comb begin
        x_wide = {{EXT_W{x_i[EXT_W-1]}}, x_i};
        y_wide = {{EXT_W{y_i[EXT_W-1]}}, y_i};
        p_o    = x_wide * y_wide;
    end

endmodule

// File: rtl/mulx_top.sv
`timescale 1ns/1ps
module mulx_top
    import mulx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LIT_W  = 5,
    parameter int BYTE_W = 8,
    localparam int EXT_W  = DATA_W + 1,
    localparam int FULL_W = 2 * EXT_W,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [LIT_W-1:0]    lit_i,
    output logic                valid_o,
    output logic [PROD_W-1:0]   product_o
);

    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] prod;
    } state_t;

    logic [EXT_W-1:0]  a_ext, b_ext;
    logic [FULL_W-1:0] full_prod;
    state_t            state_d, state_q;

    mulx_operand_prep #(
        .DATA_W (DATA_W),
        .LIT_W  (LIT_W),
        .BYTE_W (BYTE_W)
    ) prep_i (
        .mode_i  (mode_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .lit_i   (lit_i),
        .a_ext_o (a_ext),
        .b_ext_o (b_ext)
    );

    mulx_core #(
        .EXT_W (EXT_W)
    ) core_i (
        .x_i (a_ext),
        .y_i (b_ext),
        .p_o (full_prod)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = valid_i;
        if (valid_i) begin
            state_d.prod = full_prod[PROD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o   = state_q.vld;
    assign product_o = state_q.prod;

endmodule

// File: rtl/mulx_checker.sv
`timescale 1ns/1ps
module mulx_checker #(
    parameter int DATA_W = 16,
    parameter int LIT_W  = 5,
    localparam int PROD_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [2:0]        mode_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              valid_o,
    input logic [PROD_W-1:0] product_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (valid_o == $past(valid_i)));                             // R8

    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(valid_i)) |-> $stable(product_o));                 // R9

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && valid_o && $past(mode_i) == 3'd6)
            |-> (product_o[PROD_W-1:DATA_W] == '0));                          // R6

    AST_ULIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && valid_o && $past(mode_i) == 3'd5)
            |-> (product_o[PROD_W-1:DATA_W+LIT_W] == '0));                    // R5

    AST_UU_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && valid_o && $past(mode_i) == 3'd1)
            |-> (product_o == ({{DATA_W{1'b0}}, $past(a_i)}
                               * {{DATA_W{1'b0}}, $past(b_i)})));             // R2

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && valid_o && $past(mode_i) == 3'd7) |-> (product_o == '0)); // R7

endmodule

bind mulx_top mulx_checker #(
    .DATA_W (DATA_W),
    .LIT_W  (LIT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .mode_i    (mode_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .valid_o   (valid_o),
    .product_o (product_o)
);

// File: tb/mulx_top_tb_top.sv
`timescale 1ns/1ps
module mulx_top_tb_top;

    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] a_i = 16'd0;
    logic [15:0] b_i = 16'd0;
    logic [4:0]  lit_i = 5'd0;
    logic        valid_o;
    logic [31:0] product_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mulx_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .mode_i    (mode_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .lit_i     (lit_i),
        .valid_o   (valid_o),
        .product_o (product_o)
    );

    // Each entry: {mode[2:0], a[15:0], b[15:0], lit[4:0]}
    localparam logic [39:0] VECS [0:NVEC-1] = '{
        {3'd0, 16'h7FFF, 16'h7FFF, 5'd3},
        {3'd0, 16'h8000, 16'h7FFF, 5'd0},
        {3'd0, 16'hFFFF, 16'h1234, 5'd9},
        {3'd1, 16'hFFFF, 16'h8000, 5'd1},
        {3'd1, 16'h1234, 16'h5678, 5'd2},
        {3'd2, 16'hFFFF, 16'h8000, 5'd0},
        {3'd2, 16'h8001, 16'h0003, 5'd7},
        {3'd3, 16'h8000, 16'hFFFF, 5'd0},
        {3'd3, 16'h00FF, 16'hF00F, 5'd4},
        {3'd4, 16'hFFFF, 16'hAAAA, 5'd31},
        {3'd4, 16'h7FFF, 16'h5555, 5'd17},
        {3'd5, 16'h8000, 16'hFFFF, 5'd31},
        {3'd5, 16'h0001, 16'h1234, 5'd0},
        {3'd6, 16'hFF80, 16'h01FF, 5'd5},
        {3'd6, 16'h5A7F, 16'hA580, 5'd1},
        {3'd7, 16'h1234, 16'h5678, 5'd9}
    };

    function automatic logic [31:0] ref_prod(logic [2:0] m, logic [15:0] a,
                                             logic [15:0] b, logic [4:0] l);
        longint sa = longint'($signed(a));
        longint ua = longint'({48'd0, a});
        longint sb = longint'($signed(b));
        longint ub = longint'({48'd0, b});
        longint ul = longint'({59'd0, l});
        longint p;
        case (m)
            3'd0: p = sa * sb;
            3'd1: p = ua * ub;
            3'd2: p = ua * sb;
            3'd3: p = sa * ub;
            3'd4: p = sa * ul;
            3'd5: p = ua * ul;
            3'd6: p = longint'({56'd0, a[7:0]}) * longint'({56'd0, b[7:0]});
            default: p = 0;
        endcase
        return p[31:0];
    endfunction

    function automatic string req_of(logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge; the result is sampled one period later.
    task automatic strobe(logic [2:0] m, logic [15:0] a, logic [15:0] b, logic [4:0] l);
        @(negedge clk);
        mode_i = m; a_i = a; b_i = b; lit_i = l; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic run_one(string req, logic [2:0] m, logic [15:0] a,
                           logic [15:0] b, logic [4:0] l, logic [31:0] exp);
        strobe(m, a, b, l);
        check({req, " valid"}, {31'd0, valid_o}, 32'd1);
        check(req, product_o, exp);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 product", product_o, 32'd0);
        check("R10 valid", {31'd0, valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle valid", {31'd0, valid_o}, 32'd0);

        // Vector table against the wide reference
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0]  m = VECS[i][39:37];
            logic [15:0] a = VECS[i][36:21];
            logic [15:0] b = VECS[i][20:5];
            logic [4:0]  l = VECS[i][4:0];
            run_one(req_of(m), m, a, b, l, ref_prod(m, a, b, l));
            @(negedge clk);
            check("R8 single pulse", {31'd0, valid_o}, 32'd0);
        end

        // Directed corners with known constants
        run_one("R1", 3'd0, 16'h8000, 16'h8000, 5'd0, 32'h40000000);
        run_one("R2", 3'd1, 16'hFFFF, 16'hFFFF, 5'd0, 32'hFFFE0001);
        run_one("R3", 3'd3, 16'hFFFF, 16'hFFFF, 5'd0, 32'hFFFF0001);
        run_one("R3", 3'd2, 16'h0002, 16'hFFFE, 5'd0, 32'hFFFFFFFC);
        run_one("R4", 3'd4, 16'h8000, 16'h1234, 5'd31, 32'hFFF08000);
        run_one("R5", 3'd5, 16'hFFFF, 16'hFFFF, 5'd31, 32'h001EFFE1);
        run_one("R6", 3'd6, 16'h12FF, 16'h34FF, 5'd0, 32'h0000FE01);
        run_one("R6", 3'd6, 16'hAB02, 16'hCD03, 5'd0, 32'h00000006);
        run_one("R7", 3'd7, 16'hFFFF, 16'hFFFF, 5'd31, 32'h00000000);
        run_one("R4", 3'd4, 16'h0003, 16'hFFFF, 5'd5, 32'h0000000F);

        // R9: inputs change without a strobe, product holds
        run_one("R9 setup", 3'd1, 16'h0010, 16'h0020, 5'd0, 32'h00000200);
        mode_i = 3'd0; a_i = 16'hFFFF; b_i = 16'h7777; lit_i = 5'd9;
        @(negedge clk);
        check("R9 hold", product_o, 32'h00000200);
        check("R9 valid low", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        check("R9 hold 2", product_o, 32'h00000200);

        // R8: back-to-back strobes give back-to-back results
        @(negedge clk);
        mode_i = 3'd1; a_i = 16'd3; b_i = 16'd5; valid_i = 1'b1;
        @(negedge clk);
        check("R8 first", product_o, 32'd15);
        check("R8 first valid", {31'd0, valid_o}, 32'd1);
        mode_i = 3'd0; a_i = 16'hFFFE; b_i = 16'd7;
        @(negedge clk);
        valid_i = 1'b0;
        check("R8 second", product_o, 32'hFFFFFFF2);
        check("R8 second valid", {31'd0, valid_o}, 32'd1);
        @(negedge clk);
        check("R8 end pulse", {31'd0, valid_o}, 32'd0);

        // R10: reset mid-run clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 clear", product_o, 32'd0);
        check("R10 clear valid", {31'd0, valid_o}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule